// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the feedback divider of a frequency synthesizer. One input clock stands in for the oscillator. A 64/65 two-modulus prescaler runs on that clock. A main counter and a swallow counter select the prescaler modulus, so the block emits one single-cycle output pulse every 64·N + A input clocks. Both counters step down once per prescaler period. The swallow counter holds the prescaler at 65 while it is nonzero. It then parks at zero while the main counter finishes, and at the main counter's terminal count both counters reload.

A fixed reference divider runs on the same clock. It produces its own single-cycle comparison pulse every 1400 clocks. Software programs the division through a three-wire serial port: a data bit, a shift clock, and a latch strobe. The latch strobe validates the shifted word and installs it. The installed values reach the counters only at their next reload, so the period in progress always completes with the old values.

Top module: `pulse_swallow_divider`

## Requirements
- R1: Consecutive `div_pulse` assertions are exactly P_LOW·N + A clocks apart, where N and A are the installed values and P_LOW is the low prescaler modulus (64 by default).
- R2: `div_pulse` is high for exactly one clock per division period.
- R3: `ref_pulse` is high for one clock out of every REF_DIV clocks (1400 by default).
- R4: Both counters step once per prescaler period. The swallow count stops at zero and holds there until the main count reaches its terminal value, and then both counters reload.
- R5: In each division period, `mod_high` (the prescaler runs at P_LOW+1) is high for exactly the first A prescaler periods, which is (P_LOW+1)·A clocks. It rises only in the cycle in which `div_pulse` is high.
- R6: Each rising edge of `prog_clk` shifts `prog_data` into the serial register, most significant bit first. The word is N_W+A_W bits long. The upper N_W bits carry N and the lower A_W bits carry A.
- R7: A rising edge of `prog_latch` installs the shifted word and clears `load_err`. If the word has N = 0 or A ≥ N, the load is refused instead: `load_err` is set and the installed values stay unchanged.
- R8: Newly installed values take effect only at the next reload. The division period in progress ends after the old P_LOW·N + A clocks.
- R9: After reset, both pulses and `load_err` are low and the installed values are N_RST and A_RST. `mod_high` is high exactly when A_RST is nonzero.
- R10: With the default parameters (N = 1056, A = 60), the output period is 67644 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator stand-in clock; every register runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_clk | input | 1 | Serial shift clock, sampled by `clk`; a rising edge shifts one bit |
| prog_data | input | 1 | Serial data bit, MSB first |
| prog_latch | input | 1 | Rising edge validates and installs the shifted word |
| div_pulse | output | 1 | One-clock pulse per full division period |
| ref_pulse | output | 1 | One-clock pulse every REF_DIV clocks |
| mod_high | output | 1 | High while the prescaler divides by P_LOW+1 |
| load_err | output | 1 | Set when the last latched word was refused |

## Verification
The assertions rely on the programming inputs being synchronous to `clk`. They also rely on each high or low phase of `prog_clk` and `prog_latch` lasting at least one clock, so that each edge is seen exactly once. The configuration-change property additionally takes for granted that only the latch strobe can alter the installed values. The stimulus holds every programming level for a whole clock and changes it only between edges. It issues each latch right after an output pulse, so every period it measures belongs wholly to one configuration. A reduced instance (low modulus 4, 4-bit N, 3-bit A) is swept over every legal N and A. The default instance is checked once against the full 1056/60 case.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic {
        MOD_BASE    = 1'b0,
        MOD_SWALLOW = 1'b1
    } psd_mod_e;

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int P_LOW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  psd_pkg::psd_mod_e mod_sel,
    output logic              tc
);
    localparam int CW = $clog2(P_LOW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [CW-1:0] last;

    always_comb begin
        last = (mod_sel == psd_pkg::MOD_SWALLOW) ? CW'(P_LOW) : CW'(P_LOW - 1);
        tc   = (st_q.cnt == last);
        st_d = st_q;
        st_d.cnt = tc ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow #(
    parameter int N_W   = 12,
    parameter int A_W   = 7,
    parameter int N_RST = 1056,
    parameter int A_RST = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [N_W-1:0]    n_cfg,
    input  logic [A_W-1:0]    a_cfg,
    output psd_pkg::psd_mod_e mod_sel,
    output logic              term_pulse
);
    typedef struct packed {
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
        logic           pulse;
    } sw_st_t;

    sw_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pulse = 1'b0;
        if (step) begin
            if (st_q.n <= N_W'(1)) begin
                st_d.n     = n_cfg;
                st_d.a     = a_cfg;
                st_d.pulse = 1'b1;
            end else begin
                st_d.n = st_q.n - 1'b1;
                if (st_q.a != '0) st_d.a = st_q.a - 1'b1;
            end
        end
        mod_sel    = (st_q.a != '0) ? psd_pkg::MOD_SWALLOW : psd_pkg::MOD_BASE;
        term_pulse = st_q.pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.n     <= N_W'(N_RST);
            st_q.a     <= A_W'(A_RST);
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/psd_prog_reg.sv
module psd_prog_reg #(
    parameter int N_W   = 12,
    parameter int A_W   = 7,
    parameter int N_RST = 1056,
    parameter int A_RST = 60
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           sdata,
    input  logic           latch,
    output logic [N_W-1:0] n_cfg,
    output logic [A_W-1:0] a_cfg,
    output logic           err
);
    localparam int W     = N_W + A_W;
    localparam int CMP_W = (N_W > A_W) ? N_W : A_W;

    typedef struct packed {
        logic           sclk_prev;
        logic           latch_prev;
        logic [W-1:0]   shreg;
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
        logic           err;
    } pr_st_t;

    pr_st_t st_d, st_q;
    logic [N_W-1:0] cand_n;
    logic [A_W-1:0] cand_a;
    logic           cand_ok;

    always_comb begin
        st_d = st_q;
        st_d.sclk_prev  = sclk;
        st_d.latch_prev = latch;
        cand_n  = st_q.shreg[W-1:A_W];
        cand_a  = st_q.shreg[A_W-1:0];
        cand_ok = (cand_n != '0) && (CMP_W'(cand_a) < CMP_W'(cand_n));
        if (sclk && !st_q.sclk_prev)
            st_d.shreg = {st_q.shreg[W-2:0], sdata};
        if (latch && !st_q.latch_prev) begin
            if (cand_ok) begin
                st_d.n   = cand_n;
                st_d.a   = cand_a;
                st_d.err = 1'b0;
            end else begin
                st_d.err = 1'b1;
            end
        end
        n_cfg = st_q.n;
        a_cfg = st_q.a;
        err   = st_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev  <= 1'b0;
            st_q.latch_prev <= 1'b0;
            st_q.shreg      <= '0;
            st_q.n          <= N_W'(N_RST);
            st_q.a          <= A_W'(A_RST);
            st_q.err        <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/psd_ref_div.sv
module psd_ref_div #(
    parameter int REF_DIV = 1400
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse
);
    localparam int CW = $clog2(REF_DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic   wrap;

    always_comb begin
        wrap       = (st_q.cnt == CW'(REF_DIV - 1));
        st_d.cnt   = wrap ? '0 : st_q.cnt + 1'b1;
        st_d.pulse = wrap;
        pulse      = st_q.pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
    parameter int P_LOW   = 64,
    parameter int N_W     = 12,
    parameter int A_W     = 7,
    parameter int N_RST   = 1056,
    parameter int A_RST   = 60,
    parameter int REF_DIV = 1400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_clk,
    input  logic prog_data,
    input  logic prog_latch,
    output logic div_pulse,
    output logic ref_pulse,
    output logic mod_high,
    output logic load_err
);
    psd_pkg::psd_mod_e mod_sel;
    logic              pre_tc;
    logic [N_W-1:0]    n_cfg;
    logic [A_W-1:0]    a_cfg;

    psd_prog_reg #(.N_W(N_W), .A_W(A_W), .N_RST(N_RST), .A_RST(A_RST)) u_prog (
        .clk(clk), .rst_n(rst_n), .sclk(prog_clk), .sdata(prog_data),
        .latch(prog_latch), .n_cfg(n_cfg), .a_cfg(a_cfg), .err(load_err)
    );

    psd_prescaler #(.P_LOW(P_LOW)) u_pre (
        .clk(clk), .rst_n(rst_n), .mod_sel(mod_sel), .tc(pre_tc)
    );

    psd_swallow #(.N_W(N_W), .A_W(A_W), .N_RST(N_RST), .A_RST(A_RST)) u_sw (
        .clk(clk), .rst_n(rst_n), .step(pre_tc), .n_cfg(n_cfg), .a_cfg(a_cfg),
        .mod_sel(mod_sel), .term_pulse(div_pulse)
    );

    psd_ref_div #(.REF_DIV(REF_DIV)) u_ref (
        .clk(clk), .rst_n(rst_n), .pulse(ref_pulse)
    );

    assign mod_high = (mod_sel == psd_pkg::MOD_SWALLOW);
endmodule

module psd_checker #(
    parameter int N_W     = 12,
    parameter int A_W     = 7,
    parameter int REF_DIV = 1400
) (
    input logic           clk,
    input logic           rst_n,
    input logic           div_pulse,
    input logic           ref_pulse,
    input logic           mod_high,
    input logic           load_err,
    input logic           prog_latch,
    input logic [N_W-1:0] n_cfg,
    input logic [A_W-1:0] a_cfg
);
    localparam int CMP_W = (N_W > A_W) ? N_W : A_W;

    int   ref_gap;
    logic ref_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_gap  <= 0;
            ref_seen <= 1'b0;
        end else if (ref_pulse) begin
            ref_gap  <= 0;
            ref_seen <= 1'b1;
        end else begin
            ref_gap <= ref_gap + 1;
        end
    end

    a_r2_div_single: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    a_r3_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    a_r3_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pulse && ref_seen) |-> (ref_gap == REF_DIV - 1));

    a_r5_mod_rise_at_reload: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_high) |-> div_pulse);

    a_r7_cfg_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> ((n_cfg != '0) && (CMP_W'(a_cfg) < CMP_W'(n_cfg))));

    a_r7_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_err) |-> ($stable(n_cfg) && $stable(a_cfg)));

    a_r8_cfg_change_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(n_cfg) && $stable(a_cfg)) |-> $past(prog_latch));
endmodule

bind pulse_swallow_divider psd_checker #(.N_W(N_W), .A_W(A_W), .REF_DIV(REF_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .div_pulse(div_pulse), .ref_pulse(ref_pulse),
    .mod_high(mod_high), .load_err(load_err), .prog_latch(prog_latch),
    .n_cfg(n_cfg), .a_cfg(a_cfg)
);

// File: tb/pulse_swallow_divider_tb.sv
module pulse_swallow_divider_tb;
    localparam int SP = 4;   // small instance low modulus
    localparam int SR = 7;   // small instance reference ratio

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    logic d_div, d_ref, d_mod, d_err;
    logic s_pclk = 1'b0, s_pdata = 1'b0, s_latch = 1'b0;
    logic s_div, s_ref, s_mod, s_err;

    pulse_swallow_divider u_dut (
        .clk(clk), .rst_n(rst_n), .prog_clk(1'b0), .prog_data(1'b0), .prog_latch(1'b0),
        .div_pulse(d_div), .ref_pulse(d_ref), .mod_high(d_mod), .load_err(d_err)
    );

    pulse_swallow_divider #(.P_LOW(SP), .N_W(4), .A_W(3), .N_RST(3), .A_RST(1), .REF_DIV(SR)) u_small (
        .clk(clk), .rst_n(rst_n), .prog_clk(s_pclk), .prog_data(s_pdata), .prog_latch(s_latch),
        .div_pulse(s_div), .ref_pulse(s_ref), .mod_high(s_mod), .load_err(s_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic shift_word(input logic [6:0] w);
        for (int i = 6; i >= 0; i--) begin
            s_pdata = w[i];
            s_pclk  = 1'b1;
            @(negedge clk);
            s_pclk  = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic wait_s_pulse();
        do @(negedge clk); while (!s_div);
    endtask

    // Called at a pulse negedge; returns the period and the count of high-modulus clocks.
    task automatic measure(output int len, output int hi);
        len = 0;
        hi  = 0;
        do begin
            if (s_mod) hi++;
            len++;
            @(negedge clk);
            s_latch = 1'b0;
            if (len == 1) chk(!s_div, "R2 div_pulse single cycle", int'(s_div), 0);
        end while (!s_div);
    endtask

    // Program at a pulse, then check the old period and the new one.
    task automatic program_and_check(input int n, input int a, input int old_per, input bit expect_err);
        int len, hi, exp_per;
        shift_word({4'(n), 3'(a)});
        wait_s_pulse();
        s_latch = 1'b1;
        measure(len, hi);
        chk(len == old_per, "R8 period in progress keeps old values", len, old_per);
        chk(s_err == expect_err, "R7 load_err after latch", int'(s_err), int'(expect_err));
        exp_per = expect_err ? old_per : SP * n + a;
        measure(len, hi);
        chk(len == exp_per, expect_err ? "R7 refused load keeps period" : "R1 R6 period P*N+A", len, exp_per);
        if (!expect_err)
            chk(hi == (SP + 1) * a, "R4 R5 high-modulus clocks", hi, (SP + 1) * a);
    endtask

    task automatic small_block();
        int cur;
        cur = SP * 3 + 1;
        for (int n = 1; n <= 15; n++) begin
            for (int a = 0; a < n && a <= 7; a++) begin
                program_and_check(n, a, cur, 1'b0);
                cur = SP * n + a;
            end
        end
        program_and_check(0, 0, cur, 1'b1);
        program_and_check(5, 5, cur, 1'b1);
        program_and_check(6, 7, cur, 1'b1);
        program_and_check(2, 1, cur, 1'b0);
        chk(s_err == 1'b0, "R7 accepted load clears load_err", int'(s_err), 0);
        begin
            int gap;
            do @(negedge clk); while (!s_ref);
            gap = 0;
            do begin gap++; @(negedge clk); end while (!s_ref);
            chk(gap == SR, "R3 small reference spacing", gap, SR);
        end
    endtask

    task automatic default_block();
        int gap;
        do @(negedge clk); while (!d_ref);
        gap = 0;
        do begin
            gap++;
            @(negedge clk);
            if (gap == 1) chk(!d_ref, "R3 ref_pulse single cycle", int'(d_ref), 0);
        end while (!d_ref);
        chk(gap == 1400, "R3 reference spacing", gap, 1400);
        do @(negedge clk); while (!d_div);
        gap = 0;
        do begin gap++; @(negedge clk); end while (!d_div);
        chk(gap == 67644, "R10 default division 1056/60", gap, 67644);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!s_div && !d_div, "R9 no div pulse after reset", int'(s_div | d_div), 0);
        chk(!s_ref && !d_ref, "R9 no ref pulse after reset", int'(s_ref | d_ref), 0);
        chk(!s_err && !d_err, "R9 load_err clear after reset", int'(s_err | d_err), 0);
        chk(s_mod && d_mod, "R9 mod_high reflects nonzero A_RST", int'(s_mod & d_mod), 1);
        fork
            small_block();
            default_block();
        join
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule